// File: doc/BRIEF.md
# Quiescent-Current Screening Sequencer

This block runs a short quiescent-current screen on one die. After a start pulse it steps through a small, programmable number of static test states. For each state it raises a hold output that freezes the logic under test. It then waits a programmable number of settling cycles, requests one digitized supply-current reading, and accepts it over a valid/data handshake. The caller uses `state_idx` to choose the static pattern to apply while `hold` is high.

Each reading is checked in two ways. The first check compares it against an absolute ceiling. The second compares it against the reading taken just before it on the same die. Leakage differs a lot from die to die but stays steady within one die, so a sudden jump between two readings shows a defect even when the absolute ceiling is met.

At the end of the run the block reports a verdict, a two-bit reason code gathered over all states, and the index of the first state that failed. If the converter never answers, the run ends early with an error flag.

Top module: `qcs_screen_ctrl`

## Requirements
- R1: `hold` is high in every cycle in which `samp_req` is high, and `hold` stays high from the start of each state's hold phase until that state's reading is accepted.
- R2: `samp_req` rises exactly `settle_cycles`+2 clock cycles after `hold` rises for the same state.
- R3: One run visits `num_states` states with `state_idx` counting 0, 1, 2 and so on. A value of 0 counts as 1 state, and a value above MAX_STATES is clamped to MAX_STATES.
- R4: A reading strictly greater than `abs_limit` sets bit 0 of `fail_code`. A reading equal to the limit does not set it.
- R5: When the magnitude of the difference between a reading and the previous reading of the same run is strictly greater than `delta_limit`, bit 1 of `fail_code` is set. This holds whether the reading rose or fell, and a difference equal to the limit does not set the bit.
- R6: The first reading of a run gets no delta check. `fail_code` is the OR over all states: 2'b00 means pass, 2'b01 absolute fail only, 2'b10 delta fail only, 2'b11 both.
- R7: `first_fail_idx` holds the index of the first state whose own check failed, and holds 0 if no state failed. `pass` is 1 only when `fail_code` is 2'b00 and no timeout occurred. `done` pulses for one cycle, and the results stay unchanged until the next accepted start.
- R8: A `start` pulse that arrives while a run is in progress is ignored.
- R9: An `adc_valid` that arrives while no reading is requested is discarded.
- R10: If `adc_valid` does not come within `sample_timeout`+1 cycles of `samp_req` rising, the run ends. `timeout_err` is set, `done` pulses and `pass` is 0.
- R11: While reset is held and right after it, `hold`, `samp_req`, `busy`, `done`, `pass`, `fail_code` and `timeout_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| num_states | input | CNTW | Number of static states per run |
| settle_cycles | input | TW | Settling wait before each reading |
| sample_timeout | input | TW | Wait limit for a reading, in cycles minus one |
| abs_limit | input | DW | Absolute current ceiling |
| delta_limit | input | DW | Allowed step between consecutive readings |
| adc_valid | input | 1 | Converter reading valid |
| adc_data | input | DW | Converter reading |
| hold | output | 1 | Freeze the logic under test |
| state_idx | output | IDXW | Static state currently applied |
| samp_req | output | 1 | A reading is being requested |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run verdict |
| fail_code | output | 2 | Accumulated fail reason |
| first_fail_idx | output | IDXW | Index of the first failing state |
| timeout_err | output | 1 | The converter did not answer |

## Verification
The bench goes after the exact boundaries. A reading equal to the ceiling and a step equal to the delta limit must both pass; a design using >= instead of > would fail these dies wrongly. A downward step must be caught as well, and a design that subtracts without taking the magnitude would wrap or miss it. It also checks that a huge first reading gets no delta check even when the delta limit is 0, which catches a comparison made against a stale or zero previous value. It measures the settle wait to the cycle and injects stray valid strobes during settling; a design that samples early would record the junk value and report an absolute failure. Finally it retriggers start in the middle of a run, which would make a careless sequencer restart and ask for extra readings, and it lets the converter go silent to confirm that the run ends with the error flag set.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HOLD   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_CHECK  = 3'd4,
    ST_NEXT   = 3'd5,
    ST_DONE   = 3'd6
  } state_t;

  localparam logic [1:0] FC_PASS  = 2'b00;
  localparam logic [1:0] FC_ABS   = 2'b01;
  localparam logic [1:0] FC_DELTA = 2'b10;
endpackage

// File: rtl/qcs_down_timer.sv
module qcs_down_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (en && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && !load && expired) |=> expired); // R2
endmodule

// File: rtl/qcs_limit_check.sv
module qcs_limit_check #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] prev,
  input  logic          prev_valid,
  input  logic [DW-1:0] abs_limit,
  input  logic [DW-1:0] delta_limit,
  output logic [1:0]    code
);
  import qcs_pkg::*;

  logic [DW:0] diff;
  logic [DW:0] mag;
  logic        abs_over;
  logic        delta_over;

  always_comb begin
    diff       = {1'b0, sample} - {1'b0, prev};
    mag        = diff[DW] ? (~diff + 1'b1) : diff;
    abs_over   = (sample > abs_limit);
    delta_over = prev_valid && (mag > {1'b0, delta_limit});
    code       = FC_PASS;
    if (abs_over)   code = code | FC_ABS;
    if (delta_over) code = code | FC_DELTA;
  end
endmodule

// File: rtl/qcs_seq_fsm.sv
module qcs_seq_fsm #(
  parameter int MAX_STATES = 8,
  parameter int IDXW       = 3,
  parameter int CNTW       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CNTW-1:0]     num_states,
  input  logic                adc_valid,
  input  logic                settle_exp,
  input  logic                tmo_exp,
  output qcs_pkg::state_t     state,
  output logic [IDXW-1:0]     idx,
  output logic                at_last,
  output logic                hold,
  output logic                samp_req,
  output logic                busy,
  output logic                done
);
  import qcs_pkg::*;

  localparam int LAST_MAX = MAX_STATES - 1;

  state_t          state_d;
  logic [IDXW-1:0] last_idx;

  always_comb begin
    if (num_states == '0) begin
      last_idx = '0;
    end else if (int'(num_states) > MAX_STATES) begin
      last_idx = IDXW'(LAST_MAX);
    end else begin
      last_idx = IDXW'(num_states - 1'b1);
    end
  end

  assign at_last = (idx == last_idx);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:   if (start) state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_SETTLE;
      ST_SETTLE: if (settle_exp) state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        if (adc_valid)    state_d = ST_CHECK;
        else if (tmo_exp) state_d = ST_DONE;
      end
      ST_CHECK:  state_d = ST_NEXT;
      ST_NEXT:   state_d = at_last ? ST_DONE : ST_HOLD;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      hold     <= 1'b0;
      samp_req <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= state_d;
      hold     <= (state_d == ST_HOLD) || (state_d == ST_SETTLE) || (state_d == ST_SAMPLE);
      samp_req <= (state_d == ST_SAMPLE);
      busy     <= (state_d != ST_IDLE);
      done     <= (state_d == ST_DONE);
      if (state == ST_IDLE && start) begin
        idx <= '0;
      end else if (state == ST_NEXT && !at_last) begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_NEXT) |=> (state != ST_HOLD)); // R8
  AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && !settle_exp) |=> (state == ST_SETTLE)); // R2
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx <= last_idx)); // R3
  AST_REQ_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    samp_req |-> hold); // R1
endmodule

// File: rtl/qcs_screen_ctrl.sv
module qcs_screen_ctrl #(
  parameter int DW         = 12,
  parameter int TW         = 16,
  parameter int MAX_STATES = 8,
  parameter int IDXW       = $clog2(MAX_STATES),
  parameter int CNTW       = $clog2(MAX_STATES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CNTW-1:0] num_states,
  input  logic [TW-1:0]   settle_cycles,
  input  logic [TW-1:0]   sample_timeout,
  input  logic [DW-1:0]   abs_limit,
  input  logic [DW-1:0]   delta_limit,
  input  logic            adc_valid,
  input  logic [DW-1:0]   adc_data,
  output logic            hold,
  output logic [IDXW-1:0] state_idx,
  output logic            samp_req,
  output logic            busy,
  output logic            done,
  output logic            pass,
  output logic [1:0]      fail_code,
  output logic [IDXW-1:0] first_fail_idx,
  output logic            timeout_err
);
  import qcs_pkg::*;

  state_t        state;
  logic          at_last;
  logic          settle_exp;
  logic          tmo_exp;
  logic [DW-1:0] samp_q;
  logic [DW-1:0] prev_q;
  logic          have_prev;
  logic          ff_seen;
  logic [1:0]    chk_code;

  qcs_seq_fsm #(.MAX_STATES(MAX_STATES), .IDXW(IDXW), .CNTW(CNTW)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .num_states(num_states),
    .adc_valid(adc_valid), .settle_exp(settle_exp), .tmo_exp(tmo_exp),
    .state(state), .idx(state_idx), .at_last(at_last), .hold(hold),
    .samp_req(samp_req), .busy(busy), .done(done)
  );

  qcs_down_timer #(.W(TW)) u_settle (
    .clk(clk), .rst(rst), .load(state == ST_HOLD), .en(state == ST_SETTLE),
    .load_val(settle_cycles), .expired(settle_exp)
  );

  qcs_down_timer #(.W(TW)) u_wait (
    .clk(clk), .rst(rst), .load(state == ST_SETTLE), .en(state == ST_SAMPLE),
    .load_val(sample_timeout), .expired(tmo_exp)
  );

  qcs_limit_check #(.DW(DW)) u_check (
    .sample(samp_q), .prev(prev_q), .prev_valid(have_prev),
    .abs_limit(abs_limit), .delta_limit(delta_limit), .code(chk_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q         <= '0;
      prev_q         <= '0;
      have_prev      <= 1'b0;
      ff_seen        <= 1'b0;
      first_fail_idx <= '0;
      fail_code      <= FC_PASS;
      timeout_err    <= 1'b0;
      pass           <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          have_prev      <= 1'b0;
          ff_seen        <= 1'b0;
          first_fail_idx <= '0;
          fail_code      <= FC_PASS;
          timeout_err    <= 1'b0;
          pass           <= 1'b0;
        end
        ST_SAMPLE: begin
          if (adc_valid) begin
            samp_q <= adc_data;
          end else if (tmo_exp) begin
            timeout_err <= 1'b1;
            pass        <= 1'b0;
          end
        end
        ST_CHECK: begin
          fail_code <= fail_code | chk_code;
          if (chk_code != FC_PASS && !ff_seen) begin
            ff_seen        <= 1'b1;
            first_fail_idx <= state_idx;
          end
          prev_q    <= samp_q;
          have_prev <= 1'b1;
        end
        ST_NEXT: if (at_last) pass <= (fail_code == FC_PASS);
        default: ;
      endcase
    end
  end

  AST_ABS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHECK && samp_q > abs_limit) |=> fail_code[0]); // R4
  AST_CODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((fail_code & $past(fail_code)) == $past(fail_code))); // R6
  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> (done && !pass)); // R10
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    pass |-> (fail_code == FC_PASS && !timeout_err)); // R7
endmodule

// File: tb/test_qcs_screen_ctrl.sv
`timescale 1ns/1ps
module test_qcs_screen_ctrl;
  localparam int DW = 12;
  localparam int TW = 16;
  localparam int MAXS = 8;
  localparam int IDXW = 3;
  localparam int CNTW = 4;

  typedef struct packed {
    logic [3:0]    n;
    logic [DW-1:0] s0, s1, s2, s3;
    logic [DW-1:0] lim, dlt;
    logic [1:0]    code;
    logic [2:0]    ff;
    logic          ok;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd3, 12'd100, 12'd110, 12'd105, 12'd0,   12'd200,  12'd20,  2'b00, 3'd0, 1'b1},
    '{4'd3, 12'd100, 12'd250, 12'd240, 12'd0,   12'd200,  12'd500, 2'b01, 3'd1, 1'b0},
    '{4'd4, 12'd100, 12'd150, 12'd140, 12'd145, 12'd200,  12'd20,  2'b10, 3'd1, 1'b0},
    '{4'd2, 12'd300, 12'd50,  12'd0,   12'd0,   12'd200,  12'd100, 2'b11, 3'd0, 1'b0},
    '{4'd3, 12'd200, 12'd180, 12'd200, 12'd0,   12'd200,  12'd20,  2'b00, 3'd0, 1'b1},
    '{4'd2, 12'd150, 12'd100, 12'd0,   12'd0,   12'd200,  12'd49,  2'b10, 3'd1, 1'b0},
    '{4'd1, 12'd4095, 12'd0,  12'd0,   12'd0,   12'd4095, 12'd0,   2'b00, 3'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNTW-1:0] num_states = '0;
  logic [TW-1:0] settle_cycles = 16'd3;
  logic [TW-1:0] sample_timeout = 16'd40;
  logic [DW-1:0] abs_limit = '0;
  logic [DW-1:0] delta_limit = '0;
  logic adc_valid = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic hold, samp_req, busy, done, pass, timeout_err;
  logic [IDXW-1:0] state_idx, first_fail_idx;
  logic [1:0] fail_code;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  qcs_screen_ctrl #(.DW(DW), .TW(TW), .MAX_STATES(MAXS)) i_qcs_screen_ctrl (
    .clk(clk), .rst(rst), .start(start), .num_states(num_states),
    .settle_cycles(settle_cycles), .sample_timeout(sample_timeout),
    .abs_limit(abs_limit), .delta_limit(delta_limit),
    .adc_valid(adc_valid), .adc_data(adc_data), .hold(hold),
    .state_idx(state_idx), .samp_req(samp_req), .busy(busy), .done(done),
    .pass(pass), .fail_code(fail_code), .first_fail_idx(first_fail_idx),
    .timeout_err(timeout_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic serve(input int nsamp, input logic [DW-1:0] vals [8]);
    for (int k = 0; k < nsamp; k++) begin
      while (!samp_req) @(negedge clk);
      chk("R3 state_idx", int'(state_idx), k);
      chk("R1 hold at request", int'(hold), 1);
      adc_valid = 1'b1;
      adc_data  = vals[k];
      @(negedge clk);
      adc_valid = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] vals [8];
    int cnt;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 hold", int'(hold), 0);
    chk("R11 samp_req", int'(samp_req), 0);
    chk("R11 busy", int'(busy), 0);
    chk("R11 done/pass/code/tmo", int'({done, pass, fail_code, timeout_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 after reset busy", int'(busy), 0);

    // R4 R5 R6 R7 vector table
    for (int v = 0; v < 7; v++) begin
      num_states  = VECS[v].n;
      abs_limit   = VECS[v].lim;
      delta_limit = VECS[v].dlt;
      vals = '{VECS[v].s0, VECS[v].s1, VECS[v].s2, VECS[v].s3, '0, '0, '0, '0};
      pulse_start();
      serve(int'(VECS[v].n), vals);
      chk($sformatf("R4/R5/R6 fail_code vec%0d", v), int'(fail_code), int'(VECS[v].code));
      chk($sformatf("R7 first_fail_idx vec%0d", v), int'(first_fail_idx), int'(VECS[v].ff));
      chk($sformatf("R7 pass vec%0d", v), int'(pass), int'(VECS[v].ok));
      @(negedge clk);
      chk("R7 done is one cycle", int'(done), 0);
      chk("R7 results held", int'(fail_code), int'(VECS[v].code));
    end

    // R2 settle timing, R9 early valid discarded
    settle_cycles = 16'd5;
    num_states = 4'd1;
    abs_limit = 12'd200;
    delta_limit = 12'd10;
    pulse_start();
    while (!hold) @(negedge clk);
    cnt = 0;
    while (!samp_req) begin
      cnt++;
      if (cnt == 2) begin adc_valid = 1'b1; adc_data = 12'd4000; end
      if (cnt == 4) adc_valid = 1'b0;
      @(negedge clk);
    end
    chk("R2 settle cycles hold-to-request", cnt, 7);
    vals = '{12'd50, '0, '0, '0, '0, '0, '0, '0};
    serve(1, vals);
    chk("R9 stray valid discarded code", int'(fail_code), 0);
    chk("R9 stray valid discarded pass", int'(pass), 1);

    // R8 start while busy ignored
    settle_cycles = 16'd3;
    num_states = 4'd2;
    pulse_start();
    while (!hold) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    vals = '{12'd60, 12'd62, '0, '0, '0, '0, '0, '0};
    serve(2, vals);
    repeat (60) @(negedge clk);
    chk("R8 no restart busy", int'(busy), 0);
    chk("R8 no restart timeout", int'(timeout_err), 0);
    chk("R8 verdict", int'(pass), 1);

    // R3 zero counts as one, large clamps
    num_states = 4'd0;
    pulse_start();
    vals = '{12'd10, '0, '0, '0, '0, '0, '0, '0};
    serve(1, vals);
    chk("R3 zero states one reading pass", int'(pass), 1);
    num_states = 4'd15;
    delta_limit = 12'd100;
    pulse_start();
    for (int k = 0; k < 8; k++) vals[k] = DW'(20 + k);
    serve(8, vals);
    chk("R3 clamp run done pass", int'(pass), 1);
    chk("R3 clamp busy", int'(busy), 1);
    @(negedge clk);
    chk("R3 clamp ended", int'(busy), 0);

    // R10 timeout
    settle_cycles = 16'd2;
    sample_timeout = 16'd10;
    num_states = 4'd2;
    pulse_start();
    while (!samp_req) @(negedge clk);
    cnt = 0;
    while (samp_req) begin cnt++; @(negedge clk); end
    chk("R10 wait window", cnt, 11);
    chk("R10 done", int'(done), 1);
    chk("R10 timeout_err", int'(timeout_err), 1);
    chk("R10 pass", int'(pass), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule